// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets each CPU in a cluster interrupt itself or any set of other CPUs. Every CPU owns two interrupt kinds: a "self" kind, which only that CPU can raise on itself, and an "other" kind, which any CPU can raise on it. Each kind has its own pending bit and mask bit. A CPU's interrupt line is high while at least one of its pending kinds is unmasked.

Software reaches the block through one register write port. Each write carries the index of the CPU making it. There are four registers: send, acknowledge, mask-set and mask-clear. An event-read port returns a 32-bit event word for a chosen CPU so that the word can be merged with the main interrupt controller's event stream. The event word names the kind being delivered. Reading it as a consuming read masks that kind until software unmasks it again.

The number of CPUs is a parameter, from 1 to 32.

Top module: `ipi_unit`

## Requirements
- R1: After reset every pending bit is clear and every mask bit is set, so all `ipi_irq` bits are low and the event word is zero for every CPU.
- R2: A write to the send register (offset 0x2008) with bit 31 set makes the writing CPU's self-pending bit set.
- R3: A write to the send register sets the other-pending bit of each CPU i whose bit i (i below the CPU count) is 1. Bits naming CPUs that do not exist have no effect.
- R4: A write to the acknowledge register (offset 0x200C) clears the writing CPU's other-pending bit when bit 0 is 1 and its self-pending bit when bit 31 is 1. No other CPU's state changes.
- R5: A write to mask-set (offset 0x2024) masks the writing CPU's other kind when bit 0 is 1 and its self kind when bit 31 is 1. A write to mask-clear (offset 0x2028) unmasks them the same way. Writing both bits to mask-set masks both kinds.
- R6: `ipi_irq[c]` is high exactly when CPU c has a pending kind whose mask bit is clear. It takes its new value in the cycle after the write that changes the state.
- R7: The event word for `evt_cpu` has 4 in bits 23:16 and 0 in bits 31:24. Its bits 15:0 hold 1 when the other kind is deliverable and 2 when only the self kind is deliverable. When both are deliverable, the other kind is reported first. When nothing is deliverable the word is zero.
- R8: An event read (`evt_rd_en`) sets the mask bit of the kind it reports, taking effect at that clock edge, and leaves the pending bit set. A read that reports nothing changes no state.
- R9: Writes to any other offset change no state.
- R10: If an event read masks a kind in the same cycle that a mask-clear write unmasks it, the kind ends up masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW (16) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CPU_W | Index of the CPU making the write |
| evt_rd_en | input | 1 | Consuming event read strobe |
| evt_cpu | input | CPU_W | CPU whose event word is presented |
| evt_word | output | 32 | Event word for `evt_cpu` (combinational) |
| ipi_irq | output | NUM_CPU | Per-CPU interrupt line |

## Verification
A write or an event read takes effect at the rising edge that samples it. The new state shows on `ipi_irq` and `evt_word` during the cycle after that edge, one cycle of latency. `evt_word` also follows `evt_cpu` combinationally within the same cycle. The bench drives every input on the falling edge and keeps a behavioural model that updates on the rising edge. At the next falling edge it compares both outputs against the model, so each result is checked exactly one cycle after the stimulus that caused it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int DW = 32;

  localparam logic [15:0] OFS_SEND = 16'h2008;
  localparam logic [15:0] OFS_ACK  = 16'h200C;
  localparam logic [15:0] OFS_MSET = 16'h2024;
  localparam logic [15:0] OFS_MCLR = 16'h2028;

  localparam int OTHER_BIT = 0;
  localparam int SELF_BIT  = 31;

  localparam logic [7:0]  EVT_KIND_IPI = 8'd4;
  localparam logic [15:0] CODE_OTHER   = 16'd1;
  localparam logic [15:0] CODE_SELF    = 16'd2;

  // per-CPU update controls produced by the decoder
  typedef struct packed {
    logic pend_set_o;
    logic pend_set_s;
    logic pend_clr_o;
    logic pend_clr_s;
    logic mask_set_o;
    logic mask_set_s;
    logic mask_clr_o;
    logic mask_clr_s;
  } ipi_ctl_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2,
  parameter int AW      = 16
) (
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [CPU_W-1:0]   wcpu,
  input  logic               rd_en,
  input  logic [CPU_W-1:0]   rcpu,
  input  logic [NUM_CPU-1:0] dlv_other,
  input  logic [NUM_CPU-1:0] dlv_self,
  output ipi_ctl_t           ctl [NUM_CPU]
);

  logic hit_send;
  logic hit_ack;
  logic hit_mset;
  logic hit_mclr;

  always_comb begin
    hit_send = wr_en && (addr == AW'(OFS_SEND));
    hit_ack  = wr_en && (addr == AW'(OFS_ACK));
    hit_mset = wr_en && (addr == AW'(OFS_MSET));
    hit_mclr = wr_en && (addr == AW'(OFS_MCLR));
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic own_w;
    logic own_r;
    logic rd_takes_o;
    logic rd_takes_s;

    assign own_w      = (wcpu == CPU_W'(c));
    assign own_r      = rd_en && (rcpu == CPU_W'(c));
    // a consuming read masks the kind it reports; other has priority
    assign rd_takes_o = own_r && dlv_other[c];
    assign rd_takes_s = own_r && !dlv_other[c] && dlv_self[c];

    always_comb begin
      ctl[c].pend_set_o = hit_send && wdata[c];
      ctl[c].pend_set_s = hit_send && own_w && wdata[SELF_BIT];
      ctl[c].pend_clr_o = hit_ack  && own_w && wdata[OTHER_BIT];
      ctl[c].pend_clr_s = hit_ack  && own_w && wdata[SELF_BIT];
      ctl[c].mask_set_o = (hit_mset && own_w && wdata[OTHER_BIT]) || rd_takes_o;
      ctl[c].mask_set_s = (hit_mset && own_w && wdata[SELF_BIT])  || rd_takes_s;
      ctl[c].mask_clr_o = hit_mclr && own_w && wdata[OTHER_BIT];
      ctl[c].mask_clr_s = hit_mclr && own_w && wdata[SELF_BIT];
    end
  end

endmodule

// File: rtl/ipi_slice.sv
module ipi_slice
  import ipi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ipi_ctl_t ctl,
  output logic     dlv_other,
  output logic     dlv_self,
  output logic     irq
);

  logic pend_o_q, pend_s_q, mask_o_q, mask_s_q;
  logic pend_o_d, pend_s_d, mask_o_d, mask_s_d;
  logic upd_en;

  // next state: set terms dominate clear terms
  always_comb begin
    upd_en   = |ctl;
    pend_o_d = (pend_o_q & ~ctl.pend_clr_o) | ctl.pend_set_o;
    pend_s_d = (pend_s_q & ~ctl.pend_clr_s) | ctl.pend_set_s;
    mask_o_d = (mask_o_q & ~ctl.mask_clr_o) | ctl.mask_set_o;
    mask_s_d = (mask_s_q & ~ctl.mask_clr_s) | ctl.mask_set_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o_q <= 1'b0;
      pend_s_q <= 1'b0;
      mask_o_q <= 1'b1;
      mask_s_q <= 1'b1;
    end else if (upd_en) begin
      pend_o_q <= pend_o_d;
      pend_s_q <= pend_s_d;
      mask_o_q <= mask_o_d;
      mask_s_q <= mask_s_d;
    end
  end

  assign dlv_other = pend_o_q & ~mask_o_q;
  assign dlv_self  = pend_s_q & ~mask_s_q;
  assign irq       = dlv_other | dlv_self;

endmodule

// File: rtl/ipi_evt_mux.sv
module ipi_evt_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic [NUM_CPU-1:0] dlv_other,
  input  logic [NUM_CPU-1:0] dlv_self,
  input  logic [CPU_W-1:0]   sel,
  output logic [DW-1:0]      word
);

  logic sel_ok;
  logic sel_o;
  logic sel_s;

  always_comb begin
    sel_ok = ({1'b0, sel} < (CPU_W+1)'(NUM_CPU));
    sel_o  = 1'b0;
    sel_s  = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sel_ok && (sel == CPU_W'(i))) begin
        sel_o = dlv_other[i];
        sel_s = dlv_self[i];
      end
    end
    word = '0;
    if (sel_o) begin
      word = {8'h00, EVT_KIND_IPI, CODE_OTHER};
    end else if (sel_s) begin
      word = {8'h00, EVT_KIND_IPI, CODE_SELF};
    end
  end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int AW      = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [CPU_W-1:0]   reg_cpu,
  input  logic               evt_rd_en,
  input  logic [CPU_W-1:0]   evt_cpu,
  output logic [31:0]        evt_word,
  output logic [NUM_CPU-1:0] ipi_irq
);

  ipi_ctl_t           ctl [NUM_CPU];
  logic [NUM_CPU-1:0] dlv_other;
  logic [NUM_CPU-1:0] dlv_self;

  ipi_decode #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W),
    .AW      (AW)
  ) i_decode (
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .wcpu      (reg_cpu),
    .rd_en     (evt_rd_en),
    .rcpu      (evt_cpu),
    .dlv_other (dlv_other),
    .dlv_self  (dlv_self),
    .ctl       (ctl)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_slice
    ipi_slice i_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl[c]),
      .dlv_other (dlv_other[c]),
      .dlv_self  (dlv_self[c]),
      .irq       (ipi_irq[c])
    );
  end

  ipi_evt_mux #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
  ) i_evt_mux (
    .dlv_other (dlv_other),
    .dlv_self  (dlv_self),
    .sel       (evt_cpu),
    .word      (evt_word)
  );

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int AW      = 16,
  parameter int CPU_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [AW-1:0]      reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [CPU_W-1:0]   reg_cpu,
  input logic               evt_rd_en,
  input logic [CPU_W-1:0]   evt_cpu,
  input logic [31:0]        evt_word,
  input logic [NUM_CPU-1:0] ipi_irq
);

  logic known_ofs;
  assign known_ofs = (reg_addr == AW'(OFS_SEND)) || (reg_addr == AW'(OFS_ACK)) ||
                     (reg_addr == AW'(OFS_MSET)) || (reg_addr == AW'(OFS_MCLR));

  // R1: lines stay low while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (ipi_irq == '0);
    end
  end

  // R4: acknowledging both kinds drops the writer's line
  assert_ack_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == AW'(OFS_ACK) && reg_wdata[0] && reg_wdata[31])
    |=> !ipi_irq[$past(reg_cpu)]);

  // R5: masking both kinds drops the writer's line
  assert_mask_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == AW'(OFS_MSET) && reg_wdata[0] && reg_wdata[31])
    |=> !ipi_irq[$past(reg_cpu)]);

  // R6: line and event word agree for the selected CPU
  assert_irq_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, evt_cpu} < (CPU_W+1)'(NUM_CPU)) |-> (ipi_irq[evt_cpu] == (evt_word != 32'd0)));

  // R7: event word format
  assert_evt_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_word != 32'd0) |-> (evt_word[31:16] == 16'h0004 &&
                             (evt_word[15:0] == 16'd1 || evt_word[15:0] == 16'd2)));

  // R8: a consuming read of an other-kind event removes it
  assert_read_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_en && !reg_wr_en && evt_word[15:0] == 16'd1)
    |=> (evt_cpu != $past(evt_cpu)) || (evt_word[15:0] != 16'd1));

  // R9: unknown offsets leave the lines alone
  assert_unknown_ofs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !known_ofs && !evt_rd_en) |=> $stable(ipi_irq));

endmodule

bind ipi_unit ipi_unit_chk #(
  .NUM_CPU (NUM_CPU),
  .AW      (AW),
  .CPU_W   (CPU_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_cpu   (reg_cpu),
  .evt_rd_en (evt_rd_en),
  .evt_cpu   (evt_cpu),
  .evt_word  (evt_word),
  .ipi_irq   (ipi_irq)
);

// File: tb/test_ipi_unit.sv
`timescale 1ns/1ps
module test_ipi_unit;

  localparam int N     = 4;
  localparam int CW    = $clog2(N);
  localparam logic [15:0] A_SEND = 16'h2008;
  localparam logic [15:0] A_ACK  = 16'h200C;
  localparam logic [15:0] A_MSET = 16'h2024;
  localparam logic [15:0] A_MCLR = 16'h2028;

  logic          clk;
  logic          rst_n;
  logic          reg_wr_en;
  logic [15:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [CW-1:0] reg_cpu;
  logic          evt_rd_en;
  logic [CW-1:0] evt_cpu;
  logic [31:0]   evt_word;
  logic [N-1:0]  ipi_irq;

  int checks = 0;
  int fails  = 0;
  string prev_tag = "R1";

  // behavioural reference state
  logic [N-1:0] m_po, m_ps, m_mo, m_ms;

  ipi_unit #(.NUM_CPU(N), .AW(16)) i_ipi_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .evt_rd_en(evt_rd_en),
    .evt_cpu(evt_cpu), .evt_word(evt_word), .ipi_irq(ipi_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin : model
    int rc, wc;
    logic take_o, take_s;
    if (!rst_n) begin
      m_po = '0; m_ps = '0; m_mo = '1; m_ms = '1;
    end else begin
      rc = int'(evt_cpu);
      wc = int'(reg_cpu);
      take_o = evt_rd_en && m_po[rc] && !m_mo[rc];
      take_s = evt_rd_en && !take_o && m_ps[rc] && !m_ms[rc];
      if (reg_wr_en) begin
        case (reg_addr)
          A_SEND: begin
            if (reg_wdata[31]) m_ps[wc] = 1'b1;
            for (int i = 0; i < N; i++) if (reg_wdata[i]) m_po[i] = 1'b1;
          end
          A_ACK: begin
            if (reg_wdata[0])  m_po[wc] = 1'b0;
            if (reg_wdata[31]) m_ps[wc] = 1'b0;
          end
          A_MSET: begin
            if (reg_wdata[0])  m_mo[wc] = 1'b1;
            if (reg_wdata[31]) m_ms[wc] = 1'b1;
          end
          A_MCLR: begin
            if (reg_wdata[0])  m_mo[wc] = 1'b0;
            if (reg_wdata[31]) m_ms[wc] = 1'b0;
          end
          default: ;
        endcase
      end
      if (take_o) m_mo[rc] = 1'b1;
      if (take_s) m_ms[rc] = 1'b1;
    end
  end

  function automatic logic [31:0] exp_evt(int c);
    if (m_po[c] && !m_mo[c]) return 32'h0004_0001;
    if (m_ps[c] && !m_ms[c]) return 32'h0004_0002;
    return 32'd0;
  endfunction

  task automatic compare(string tag);
    logic [N-1:0] ei;
    logic [31:0]  ee;
    for (int i = 0; i < N; i++) ei[i] = (m_po[i] && !m_mo[i]) || (m_ps[i] && !m_ms[i]);
    ee = exp_evt(int'(evt_cpu));
    checks++;
    if (ipi_irq !== ei) begin
      fails++;
      $display("FAIL %s ipi_irq actual %b expected %b at %0t", tag, ipi_irq, ei, $time);
    end
    checks++;
    if (evt_word !== ee) begin
      fails++;
      $display("FAIL %s evt_word cpu%0d actual %h expected %h at %0t", tag, evt_cpu, evt_word, ee, $time);
    end
  endtask

  task automatic cyc(logic wr, logic [15:0] a, logic [31:0] d, int wc,
                     logic rd, int rc, string tag);
    @(negedge clk);
    compare(prev_tag);
    reg_wr_en = wr;
    reg_addr  = a;
    reg_wdata = d;
    reg_cpu   = CW'(wc);
    evt_rd_en = rd;
    evt_cpu   = CW'(rc);
    prev_tag  = tag;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, int wc, string tag);
    cyc(1'b1, a, d, wc, 1'b0, 0, tag);
  endtask

  task automatic look(int rc, string tag);
    cyc(1'b0, 16'h0, 32'h0, 0, 1'b0, rc, tag);
  endtask

  task automatic consume(int rc, string tag);
    cyc(1'b0, 16'h0, 32'h0, 0, 1'b1, rc, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; reg_cpu = '0;
    evt_rd_en = 1'b0; evt_cpu = '0;
    repeat (3) look(0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < N; c++) look(c, "R1");

    // R5: unmask both kinds for cpu0; nothing pending yet
    wr(A_MCLR, 32'h8000_0001, 0, "R5");
    look(0, "R5");
    // R2: cpu0 raises its self kind
    wr(A_SEND, 32'h8000_0000, 0, "R2");
    look(0, "R2");
    look(1, "R2");
    // R3: cpu1 targets cpus 2 and 3 while they are still masked
    wr(A_SEND, 32'h0000_000C, 1, "R3");
    look(2, "R3");
    wr(A_MCLR, 32'h0000_0001, 2, "R3");
    look(2, "R3");
    // R3: bits beyond the CPU count and middle bits do nothing
    wr(A_SEND, 32'h7FFF_FFF0, 3, "R3");
    look(3, "R3");
    // R9: unknown offsets
    wr(16'h2010, 32'hFFFF_FFFF, 1, "R9");
    wr(16'h2020, 32'hFFFF_FFFF, 2, "R9");
    wr(16'h3008, 32'hFFFF_FFFF, 0, "R9");
    look(1, "R9");
    // R7: both kinds deliverable on cpu0, other first
    wr(A_SEND, 32'h0000_0001, 1, "R7");
    look(0, "R7");
    // R8: consuming reads step through the kinds, then nothing changes
    consume(0, "R8");
    consume(0, "R8");
    consume(0, "R8");
    look(0, "R8");
    // R4: ack self only on cpu0, then unmask and see other remains
    wr(A_ACK, 32'h8000_0000, 0, "R4");
    wr(A_MCLR, 32'h8000_0001, 0, "R4");
    look(0, "R4");
    wr(A_ACK, 32'h0000_0001, 3, "R4");
    look(2, "R4");
    wr(A_ACK, 32'h0000_0001, 0, "R4");
    look(0, "R4");
    // R10: consuming read and mask-clear for the same kind in one cycle
    cyc(1'b1, A_MCLR, 32'h0000_0001, 2, 1'b1, 2, "R10");
    look(2, "R10");
    // R5: mask both kinds at once on cpu2
    wr(A_MCLR, 32'h8000_0001, 2, "R5");
    wr(A_SEND, 32'h8000_0000, 2, "R5");
    look(2, "R5");
    wr(A_MSET, 32'h8000_0001, 2, "R5");
    look(2, "R5");

    // R6: mixed traffic
    for (int k = 0; k < 600; k++) begin
      logic [15:0] a;
      logic [31:0] d;
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: a = A_SEND;
        1: a = A_ACK;
        2: a = A_MSET;
        3, 4: a = A_MCLR;
        default: a = 16'h2004;
      endcase
      d = $urandom;
      if ($urandom % 2 == 0) d = d & 32'h8000_000F;
      cyc(($urandom % 4) != 0, a, d, int'($urandom % N),
          ($urandom % 3) == 0, int'($urandom % N), "R6");
    end
    look(0, "R6");
    look(1, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule